// File: doc/BRIEF.md
# Dual-Modulus Swallow-Counter Frequency Divider

This block divides a high-rate stream of input enables by a programmable integer. It uses the classic pulse-swallow structure. A prescaler divides by 8, or by 9 while it is swallowing. A swallow counter sets how many prescaler periods at the start of each divider cycle use the longer modulus. A main counter counts prescaler periods until the divider cycle is complete. With a main count M and a swallow count A, one divider cycle lasts 8·M+A input enables. The prescaler itself only ever compares against two fixed terminal counts.

An 11-bit configuration word drives the block continuously. The upper eight bits give M and the lower three bits give A. The word is captured only while reset is asserted and at the end of each divider cycle. A change made in mid-cycle therefore never produces a shortened or stretched cycle. Each completed cycle produces a single one-clock output pulse. The input enable is a plain per-clock qualifier with no back-pressure: the block accepts every enable presented and never stalls the source.

Top module: `dmd_divider`

## Requirements
- R1: For a configuration with A < M, successive output pulses are exactly 8·M+A input enables apart. The swallow count A uses the longer prescaler modulus (9) for its first A prescaler periods and 8 for the rest.
- R2: The configuration word is split as bits [10:3] = M (unsigned) and bits [2:0] = A (unsigned). The smallest legal modulus is 8 (M=1, A=0) and the largest is 2047 (M=255, A=7).
- R3: With A = 0 the interval is exactly 8·M enables.
- R4: A configuration change takes effect only for the divider cycle that begins after the next output-producing enable. The cycle in progress keeps its captured M and A.
- R5: The output pulse is high for exactly one clock. It goes high in the clock after the enable that completes a cycle.
- R6: Clocks with the input enable low do not advance the divider. The interval is counted in enables, not in clocks.
- R7: A synchronous reset clears all counters and the output pulse, captures the present configuration word, and starts a fresh full cycle when it is released.
- R8: The flag cfg_bad is high, combinationally from the configuration input, exactly when A ≥ M. This includes M = 0.
- R9: With an illegal configuration the divider keeps producing pulses. If A ≥ M the interval is 9·M enables, and M = 0 acts as M = 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_en | input | 1 | Input enable from the oscillator being divided, one per counted edge |
| cfg_word | input | 11 | Divider configuration: [10:3] main count, [2:0] swallow count |
| out_pulse | output | 1 | One-clock pulse per completed divider cycle |
| cfg_bad | output | 1 | Configuration word has swallow count not below main count |

## Verification
Two events can fall into the same clock: a configuration change and the enable that ends a divider cycle. The bench provokes this by rewriting the word in the middle of a cycle, and also at the moment a pulse is due. A reference model that counts enables then judges whether the running cycle kept its old length and whether the new word governs the cycle after it. The second pair is a reset that arrives partway through a cycle while enables continue. The bench checks that the next interval is a full fresh cycle, counted from the release of reset.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
  // prescaler base modulus is 2**PRE_LOG, swallowing adds one
  localparam int PRE_LOG = 3;
  localparam int CFG_W   = 11;
  localparam int M_W     = CFG_W - PRE_LOG;

  typedef logic [M_W-1:0]     m_t;
  typedef logic [PRE_LOG-1:0] a_t;
  typedef logic [PRE_LOG:0]   pcnt_t;
endpackage

// File: rtl/dmd_prescaler.sv
module dmd_prescaler
  import dmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_en,
  input  logic  long_mode,
  output pcnt_t cnt,
  output logic  tick
);
  localparam pcnt_t LAST_SHORT = pcnt_t'((1 << PRE_LOG) - 1);
  localparam pcnt_t LAST_LONG  = pcnt_t'(1 << PRE_LOG);

  pcnt_t last;
  assign last = long_mode ? LAST_LONG : LAST_SHORT;
  assign tick = in_en && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || tick) cnt <= '0;
    else if (in_en)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dmd_swallow.sv
module dmd_swallow
  import dmd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic tick,
  input  a_t   load_val,
  output a_t   left,
  output logic long_mode
);
  assign long_mode = (left != '0);

  always_ff @(posedge clk) begin
    if (rst || restart)          left <= load_val;
    else if (tick && long_mode)  left <= left - 1'b1;
  end
endmodule

// File: rtl/dmd_main_cnt.sv
module dmd_main_cnt
  import dmd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  m_t   limit,
  output m_t   cnt,
  output logic wrap
);
  m_t last;
  assign last = limit - 1'b1;  // limit 0 wraps to the full range
  assign wrap = tick && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || wrap) cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dmd_divider.sv
module dmd_divider
  import dmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_en,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             out_pulse,
  output logic             cfg_bad
);
  m_t    cfg_m;
  a_t    cfg_a;
  m_t    cur_m;
  pcnt_t pre_cnt;
  m_t    m_cnt;
  a_t    a_left;
  logic  pre_tick;
  logic  long_mode;
  logic  cycle_end;

  assign cfg_m   = cfg_word[CFG_W-1:PRE_LOG];
  assign cfg_a   = cfg_word[PRE_LOG-1:0];
  assign cfg_bad = (M_W'(cfg_a) >= cfg_m);

  dmd_prescaler u_pre (
    .clk(clk), .rst(rst), .in_en(in_en), .long_mode(long_mode),
    .cnt(pre_cnt), .tick(pre_tick)
  );

  dmd_swallow u_swl (
    .clk(clk), .rst(rst), .restart(cycle_end), .tick(pre_tick),
    .load_val(cfg_a), .left(a_left), .long_mode(long_mode)
  );

  dmd_main_cnt u_main (
    .clk(clk), .rst(rst), .tick(pre_tick), .limit(cur_m),
    .cnt(m_cnt), .wrap(cycle_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_m     <= cfg_m;
      out_pulse <= 1'b0;
    end else begin
      if (cycle_end) cur_m <= cfg_m;
      out_pulse <= cycle_end;
    end
  end
endmodule

// File: rtl/dmd_divider_chk.sv
module dmd_divider_chk
  import dmd_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  in_en,
  input logic  out_pulse,
  input logic  cycle_end,
  input m_t    cur_m,
  input m_t    m_cnt,
  input pcnt_t pre_cnt
);
  // R5: pulse lasts one clock (cycles are at least 8 enables)
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    out_pulse |=> !out_pulse);

  // R6: a cycle can only end on an accepted enable
  p_end_on_enable_r6: assert property (@(posedge clk) disable iff (rst)
    cycle_end |-> in_en);

  // R4: captured main count only moves at a cycle boundary
  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !cycle_end |=> $stable(cur_m));

  // R9: main counter stays inside its window, so no lock-up
  p_mcnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
    (cur_m != '0) |-> (m_cnt < cur_m));

  // R1: prescaler never exceeds the long modulus
  p_pre_bound_r1: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= pcnt_t'(1 << PRE_LOG));
endmodule

bind dmd_divider dmd_divider_chk i_chk (
  .clk(clk), .rst(rst), .in_en(in_en), .out_pulse(out_pulse),
  .cycle_end(cycle_end), .cur_m(cur_m), .m_cnt(m_cnt), .pre_cnt(pre_cnt)
);

// File: tb/test_dmd_divider.sv
`timescale 1ns/1ps
module test_dmd_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_en = 1'b0;
  logic [10:0] cfg_word = 11'h008;
  logic        out_pulse;
  logic        cfg_bad;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int gap_pct = 0;        // percent of clocks with enable low
  string cur_req = "R7";
  bit done = 0;

  always #2.5 clk = ~clk;

  dmd_divider i_dmd_divider (
    .clk(clk), .rst(rst), .in_en(in_en), .cfg_word(cfg_word),
    .out_pulse(out_pulse), .cfg_bad(cfg_bad)
  );

  function automatic int modulus(logic [10:0] w);
    int m = int'(w[10:3]);
    int a = int'(w[2:0]);
    if (m == 0) m = 256;
    if (a >= m) return 9 * m;
    return 8 * m + a;
  endfunction

  // behavioural reference: counts enables against the captured modulus
  int  k_cur = 8;
  int  n_en = 0;
  int  last_k = 0;
  int  last_n = 0;
  bit  exp_pulse = 0;
  int  pulses = 0;
  always @(posedge clk) begin
    cycles++;
    exp_pulse = 0;
    if (rst) begin
      n_en = 0;
      k_cur = modulus(cfg_word);
    end else if (in_en) begin
      n_en++;
      if (n_en == k_cur) begin
        exp_pulse = 1;
        last_k = k_cur;
        last_n = n_en;
        n_en = 0;
        k_cur = modulus(cfg_word);
      end
    end
  end

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(cur_req, out_pulse, exp_pulse);
      if (exp_pulse && out_pulse) begin
        pulses++;
        check({cur_req, " interval"}, last_n, last_k);
      end
    end
  end

  // drive enables according to the gap setting
  always @(posedge clk) begin
    #1;
    in_en <= ($urandom_range(99) >= gap_pct);
  end

  always @(posedge clk) begin
    if (cycles > 190000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic set_cfg(int m, int a);
    @(posedge clk); #1;
    cfg_word = {8'(m), 3'(a)};
  endtask

  task automatic wait_pulses(int n);
    int target = pulses + n;
    while (pulses < target) @(negedge clk);
  endtask

  task automatic chk_flag(int m, int a);
    set_cfg(m, a);
    @(negedge clk);
    check("R8 flag", cfg_bad, (a >= m) ? 1 : 0);
  endtask

  int ms[8] = '{1, 2, 3, 5, 8, 17, 64, 255};

  initial begin
    // R7: reset state
    cur_req = "R7";
    repeat (4) @(negedge clk);
    check("R7 reset out", out_pulse, 0);
    @(posedge clk); #1; rst = 0;

    // R3: no swallowing, continuous enables
    cur_req = "R3";
    set_cfg(4, 0);
    wait_pulses(4);

    // R1 R2 R6: sampled sweep of legal pairs, with enable gaps
    cur_req = "R1";
    for (int i = 0; i < 8; i++) begin
      for (int a = 0; a < 8 && a < ms[i]; a++) begin
        gap_pct = (a % 2) ? 30 : 0;
        cur_req = (a % 2) ? "R6" : "R1";
        set_cfg(ms[i], a);
        wait_pulses(2);
      end
    end
    gap_pct = 0;

    // R2: extreme legal moduli 8 and 2047
    cur_req = "R2";
    set_cfg(1, 0);   wait_pulses(3);
    set_cfg(255, 7); wait_pulses(2);

    // R4: rewrite mid-cycle; running cycle keeps its length
    cur_req = "R4";
    set_cfg(10, 3); wait_pulses(2);
    repeat (20) @(posedge clk);
    set_cfg(2, 1);
    wait_pulses(1);
    check("R4 kept old length", last_k, 83);
    wait_pulses(1);
    check("R4 new length", last_k, 17);
    // change right at a boundary as well
    set_cfg(3, 2); wait_pulses(1);
    set_cfg(6, 5); wait_pulses(3);

    // R8: flag decoding
    chk_flag(3, 2); chk_flag(3, 3); chk_flag(2, 7); chk_flag(0, 0); chk_flag(200, 7);

    // R9: illegal words keep the divider alive
    cur_req = "R9";
    set_cfg(3, 5); wait_pulses(3);
    check("R9 interval 9M", last_k, 27);
    set_cfg(0, 0); wait_pulses(2);
    check("R9 zero main", last_k, 2048);

    // R7: reset in mid-cycle restarts a full cycle
    cur_req = "R7";
    set_cfg(5, 2); wait_pulses(1);
    repeat (13) @(posedge clk);
    #1; rst = 1;
    repeat (2) @(posedge clk);
    #1; rst = 0;
    wait_pulses(2);
    check("R7 fresh cycle", last_k, 42);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule